// File: doc/BRIEF.md
# EPROM Word Programming Sequencer

This block burns 16-bit words into an electrically programmable, UV-erasable or one-time-programmable memory, one address at a time. A host offers an address and a data word through a valid/ready handshake. The sequencer then raises the high-voltage programming supply enable, presents the address and drives the data pins. After a settle time it pulls the program strobe low for a fixed number of clock cycles. It then releases the data pins and reads the cell back, and reports a result for that word.

The memory's operating mode is set only by the levels of its chip-select, read-enable and program strobe. While writing, chip-select is low and read-enable is high, so the memory's pins are inputs. While checking, chip-select and read-enable are both low and the strobe is high, so the memory drives the stored word. If the host marks a request as inhibited, for example because another device in the array is being written, chip-select stays high for the whole slot. The memory then ignores the strobe and keeps its pins floating. A word that does not read back correctly receives up to a parameterised number of additional pulses before it is reported as failed. All times are parameterised clock-cycle counts. The default pulse is 20000 cycles, which is about 100 µs at 200 MHz.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset the supply enable and data-pin enable are low, and chip-select, read-enable and program strobe (all active low) are high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle and `pwr_good` is high.
- R3: `vpp_en` rises in the cycle after a request is taken. It stays high through the last read-back cycle of the word, or through the last pulse cycle of an inhibited word, and is low during the one-cycle result slot. It is never high while `pwr_good` is low.
- R4: Each write round begins with SETUP_CYC cycles in which chip-select is low, read-enable is high and the data pins are driven with the accepted word. The program strobe is then low for exactly PULSE_CYC cycles.
- R5: After the pulse, RECOV_CYC cycles keep the data pins driven with the strobe high. Then VERIFY_CYC cycles follow with read-enable low, chip-select low, strobe high and data pins released. The returned word is compared in the last of these cycles.
- R6: The data-pin enable is high only while read-enable to the memory is high.
- R7: On a match, `done` is high for one cycle with `pass`=1 and `fail`=0. `pass` and `fail` are never both high, and neither is high without `done`.
- R8: On a mismatch with fewer than MAX_RETRY extra rounds used, a new setup/pulse/read-back round starts in the next cycle, with no `done`.
- R9: On a mismatch after MAX_RETRY extra rounds (MAX_RETRY+1 pulses in all), `done` is high for one cycle with `fail`=1 and `pass`=0.
- R10: A request taken with `req_inhibit`=1 keeps chip-select high and the data pins released for the whole slot. It still times the setup and the strobe pulse, skips read-back, and ends with `done`=1, `pass`=0, `fail`=0. The memory cell is left unchanged.
- R11: `mem_addr` holds the accepted address, and `mem_dq_out` holds the accepted word, from the cycle after acceptance until the block is idle again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Main supply present |
| req_valid | input | 1 | Host offers a word |
| req_ready | output | 1 | Sequencer can take a word |
| req_addr | input | 17 | Word address |
| req_data | input | 16 | Word to write |
| req_inhibit | input | 1 | Run the slot with this device deselected |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | Word read back correctly (with done) |
| fail | output | 1 | Word failed after all retries (with done) |
| vpp_en | output | 1 | Programming supply enable |
| mem_addr | output | 17 | Address to memory |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Enable for the data-pin drivers |
| mem_dq_in | input | 16 | Data read from memory pins |
| mem_ce_n | output | 1 | Chip-select, active low |
| mem_oe_n | output | 1 | Read-enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |

## Verification
The supply assertions assume that `pwr_good` stays high from the moment a word is taken until its result strobe. The block does not abort a word on supply loss, so a drop in mid-word would fire them. The stimulus therefore lowers `pwr_good` only while the block is idle. The bench shows that no request is taken in that window. The read-back word is assumed valid in the last verify cycle. The bench's memory model drives it combinationally from the pin levels. That model applies a write only on a strobe falling edge with chip-select low and read-enable high, and can be told to need several pulses before a cell takes its value.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_PULSE  = 3'd2,
      ST_RECOV  = 3'd3,
      ST_VERIFY = 3'd4,
      ST_DONE   = 3'd5
   } seq_st_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/eprom_prog_timer.sv
module eprom_prog_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [CW-1:0] limit,
   output logic          expire
);

   logic [CW-1:0] cnt_q;

   assign expire = (cnt_q == (limit - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (restart)    cnt_q <= '0;
      else if (!expire)    cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/eprom_prog_retry.sv
module eprom_prog_retry #(
   parameter int MAX_RETRY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bump,
   output logic exhausted
);

   localparam int RW = $clog2(MAX_RETRY + 2);

   logic [RW-1:0] used_q;

   assign exhausted = (used_q == RW'(MAX_RETRY));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  used_q <= '0;
      else if (clear)              used_q <= '0;
      else if (bump && !exhausted) used_q <= used_q + 1'b1;
   end

endmodule

// File: rtl/eprom_prog_pins.sv
module eprom_prog_pins
   import eprom_prog_pkg::*;
(
   input  seq_st_e st,
   input  logic    inh,
   output logic    vpp_en,
   output logic    ce_n,
   output logic    oe_n,
   output logic    pgm_n,
   output logic    dq_oe,
   output logic    done
);

   logic active;
   logic writing;

   always_comb begin
      active  = (st == ST_SETUP) || (st == ST_PULSE) ||
                (st == ST_RECOV) || (st == ST_VERIFY);
      writing = (st == ST_SETUP) || (st == ST_PULSE) || (st == ST_RECOV);
      vpp_en  = active;
      ce_n    = !(active && !inh);
      oe_n    = !((st == ST_VERIFY) && !inh);
      pgm_n   = (st != ST_PULSE);
      dq_oe   = writing && !inh;
      done    = (st == ST_DONE);
   end

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
   import eprom_prog_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 16,
   parameter int SETUP_CYC  = 4,
   parameter int PULSE_CYC  = 20000,
   parameter int RECOV_CYC  = 4,
   parameter int VERIFY_CYC = 4,
   parameter int MAX_RETRY  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_good,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_inhibit,
   output logic              done,
   output logic              pass,
   output logic              fail,
   output logic              vpp_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_pgm_n
);

   localparam int MAXC = max2(max2(SETUP_CYC, PULSE_CYC), max2(RECOV_CYC, VERIFY_CYC));
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (SETUP_CYC < 1)  begin : g_bad_setup  $error("SETUP_CYC must be at least 1");  end
      if (PULSE_CYC < 1)  begin : g_bad_pulse  $error("PULSE_CYC must be at least 1");  end
      if (RECOV_CYC < 1)  begin : g_bad_recov  $error("RECOV_CYC must be at least 1");  end
      if (VERIFY_CYC < 1) begin : g_bad_verify $error("VERIFY_CYC must be at least 1"); end
      if (MAX_RETRY < 0)  begin : g_bad_retry  $error("MAX_RETRY must not be negative"); end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width $error("widths must be positive"); end
   endgenerate

   seq_st_e           st_q, st_nxt;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              inh_q;
   logic              res_pass_q, res_fail_q;
   logic [CW-1:0]     limit;
   logic              expire;
   logic              restart;
   logic              exhausted;
   logic              accept;
   logic              match;
   logic              bump;
   logic              verify_end;

   assign req_ready  = (st_q == ST_IDLE) && pwr_good;
   assign accept     = req_valid && req_ready;
   assign match      = (mem_dq_in == data_q);
   assign verify_end = (st_q == ST_VERIFY) && expire;
   assign bump       = verify_end && !match && !exhausted;
   assign restart    = (st_nxt != st_q);

   always_comb begin
      case (st_q)
         ST_SETUP:  limit = CW'(SETUP_CYC);
         ST_PULSE:  limit = CW'(PULSE_CYC);
         ST_RECOV:  limit = CW'(RECOV_CYC);
         ST_VERIFY: limit = CW'(VERIFY_CYC);
         default:   limit = CW'(1);
      endcase
   end

   always_comb begin
      st_nxt = st_q;
      case (st_q)
         ST_IDLE:   if (accept) st_nxt = ST_SETUP;
         ST_SETUP:  if (expire) st_nxt = ST_PULSE;
         ST_PULSE:  if (expire) st_nxt = inh_q ? ST_DONE : ST_RECOV;
         ST_RECOV:  if (expire) st_nxt = ST_VERIFY;
         ST_VERIFY: if (expire) st_nxt = (match || exhausted) ? ST_DONE : ST_SETUP;
         ST_DONE:   st_nxt = ST_IDLE;
         default:   st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         addr_q     <= '0;
         data_q     <= '0;
         inh_q      <= 1'b0;
         res_pass_q <= 1'b0;
         res_fail_q <= 1'b0;
      end else begin
         st_q <= st_nxt;
         if (accept) begin
            addr_q     <= req_addr;
            data_q     <= req_data;
            inh_q      <= req_inhibit;
            res_pass_q <= 1'b0;
            res_fail_q <= 1'b0;
         end else if (verify_end) begin
            res_pass_q <= match;
            res_fail_q <= !match && exhausted;
         end
      end
   end

   eprom_prog_timer #(.CW(CW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .limit   (limit),
      .expire  (expire)
   );

   eprom_prog_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .bump      (bump),
      .exhausted (exhausted)
   );

   eprom_prog_pins u_pins (
      .st     (st_q),
      .inh    (inh_q),
      .vpp_en (vpp_en),
      .ce_n   (mem_ce_n),
      .oe_n   (mem_oe_n),
      .pgm_n  (mem_pgm_n),
      .dq_oe  (mem_dq_oe),
      .done   (done)
   );

   assign mem_addr   = addr_q;
   assign mem_dq_out = data_q;
   assign pass       = done && res_pass_q;
   assign fail       = done && res_fail_q;

   // R3
   vpp_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vpp_en |-> pwr_good);

   // R3
   vpp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vpp_en) |-> $past(req_valid && req_ready));

   // R6
   bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R4
   pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_pgm_n |-> (vpp_en && mem_oe_n));

   // R5
   verify_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_ce_n && mem_pgm_n && vpp_en && !mem_dq_oe));

   // R7
   res_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pass || fail) |-> (done && !(pass && fail)));

   // R10
   inh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q != ST_IDLE) && inh_q) |-> (mem_ce_n && !mem_dq_oe));

   // R11
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q != ST_IDLE) && ($past(st_q) != ST_IDLE)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

   // R2
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!vpp_en && !done));

endmodule

// File: tb/tb_eprom_prog_seq.sv
`timescale 1ns/1ps
module tb_eprom_prog_seq;

   localparam int S  = 2;
   localparam int P  = 4;
   localparam int R  = 1;
   localparam int V  = 2;
   localparam int MR = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_good = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [16:0] req_addr = '0;
   logic [15:0] req_data = '0;
   logic        req_inhibit = 1'b0;
   logic        done, pass, fail, vpp_en;
   logic [16:0] mem_addr;
   logic [15:0] mem_dq_out, mem_dq_in;
   logic        mem_dq_oe, mem_ce_n, mem_oe_n, mem_pgm_n;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   eprom_prog_seq #(
      .SETUP_CYC(S), .PULSE_CYC(P), .RECOV_CYC(R), .VERIFY_CYC(V), .MAX_RETRY(MR)
   ) dut (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_data(req_data), .req_inhibit(req_inhibit),
      .done(done), .pass(pass), .fail(fail), .vpp_en(vpp_en),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_pgm_n(mem_pgm_n)
   );

   // behavioural memory: 16 cells selected by the low address nibble
   logic [15:0] mem_arr [16];
   int          need_arr [16];
   int          pulse_arr [16];
   logic        pgm_prev = 1'b1;

   assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? mem_arr[mem_addr[3:0]] : 16'hFFFF;

   always @(posedge clk) begin
      if (rst_n) begin
         if (!mem_pgm_n && pgm_prev && !mem_ce_n && mem_oe_n && mem_dq_oe) begin
            pulse_arr[mem_addr[3:0]] = pulse_arr[mem_addr[3:0]] + 1;
            if (pulse_arr[mem_addr[3:0]] >= need_arr[mem_addr[3:0]])
               mem_arr[mem_addr[3:0]] = mem_arr[mem_addr[3:0]] & mem_dq_out;
         end
         pgm_prev = mem_pgm_n;
      end
   end

   // reference model: tick count within the current attempt
   bit          m_busy = 0, m_done = 0, m_inh = 0, m_pass = 0, m_fail = 0;
   int          m_t = 0, m_tries = 0;
   logic [16:0] m_addr = '0;
   logic [15:0] m_data = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_t = 0; m_tries = 0;
      end else if (m_done) begin
         m_done = 0;
      end else if (!m_busy) begin
         if (req_valid && pwr_good) begin
            m_busy = 1; m_t = 0; m_tries = 0;
            m_addr = req_addr; m_data = req_data; m_inh = req_inhibit;
            m_pass = 0; m_fail = 0;
         end
      end else begin
         if (m_inh && m_t == S + P - 1) begin
            m_busy = 0; m_done = 1; m_pass = 0; m_fail = 0;
         end else if (m_t == S + P + R + V - 1) begin
            if (mem_arr[m_addr[3:0]] == m_data) begin
               m_busy = 0; m_done = 1; m_pass = 1; m_fail = 0;
            end else if (m_tries < MR) begin
               m_tries = m_tries + 1; m_t = 0;
            end else begin
               m_busy = 0; m_done = 1; m_pass = 0; m_fail = 1;
            end
         end else begin
            m_t = m_t + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // per-cycle comparison of every output against the model
   always @(negedge clk) begin
      if (rst_n) begin
         bit e_pulse, e_ver, e_wr;
         e_pulse = m_busy && (m_t >= S) && (m_t < S + P);
         e_wr    = m_busy && !m_inh && (m_t < S + P + R);
         e_ver   = m_busy && !m_inh && (m_t >= S + P + R);
         chk(req_ready == (!m_busy && !m_done && pwr_good), "R2 ready", 32'(req_ready), 32'(!m_busy && !m_done && pwr_good));
         chk(vpp_en == m_busy, "R3 vpp_en", 32'(vpp_en), 32'(m_busy));
         chk(mem_ce_n == !(m_busy && !m_inh), m_inh ? "R10 ce_n" : "R4 ce_n", 32'(mem_ce_n), 32'(!(m_busy && !m_inh)));
         chk(mem_pgm_n == !e_pulse, "R4 pgm_n", 32'(mem_pgm_n), 32'(!e_pulse));
         chk(mem_oe_n == !e_ver, "R5 oe_n", 32'(mem_oe_n), 32'(!e_ver));
         chk(mem_dq_oe == e_wr, "R6 dq_oe", 32'(mem_dq_oe), 32'(e_wr));
         chk(done == m_done, "R7 done", 32'(done), 32'(m_done));
         chk(pass == (m_done && m_pass), "R7 pass", 32'(pass), 32'(m_done && m_pass));
         chk(fail == (m_done && m_fail), "R9 fail", 32'(fail), 32'(m_done && m_fail));
         if (m_busy) begin
            chk(mem_addr == m_addr, "R11 addr", 32'(mem_addr), 32'(m_addr));
            chk(mem_dq_out == m_data, "R11 data", 32'(mem_dq_out), 32'(m_data));
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         fails++;
         $display("FAIL watchdog act=%0d exp=<20000", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   bit got_pass, got_fail;

   task automatic send(input logic [16:0] a, input logic [15:0] d, input bit inh);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_data = d; req_inhibit = inh;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_inhibit = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
      got_pass = pass; got_fail = fail;
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin
         mem_arr[i] = 16'hFFFF; need_arr[i] = 1; pulse_arr[i] = 0;
      end
      need_arr[2] = 2;
      need_arr[3] = 100;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(vpp_en == 1'b0, "R1 vpp_en", 32'(vpp_en), 0);
      chk({mem_ce_n, mem_oe_n, mem_pgm_n} == 3'b111, "R1 ctrl", 32'({mem_ce_n, mem_oe_n, mem_pgm_n}), 32'h7);
      chk(mem_dq_oe == 1'b0, "R1 dq_oe", 32'(mem_dq_oe), 0);
      rst_n = 1'b1;

      // R2: no acceptance without pwr_good
      @(negedge clk);
      req_valid = 1'b1; req_addr = 17'h10001; req_data = 16'h1234;
      repeat (5) begin
         @(negedge clk);
         chk(req_ready == 1'b0 && vpp_en == 1'b0, "R2 no_pg", 32'({req_ready, vpp_en}), 0);
      end
      req_valid = 1'b0;
      pwr_good  = 1'b1;

      // R7 plain pass
      send(17'h10001, 16'h1234, 1'b0);
      wait_done();
      chk(got_pass && !got_fail, "R7 result", 32'({got_pass, got_fail}), 32'h2);
      chk(mem_arr[1] == 16'h1234, "R7 cell", 32'(mem_arr[1]), 32'h1234);

      // R8 retry then pass
      send(17'h00002, 16'hA5A5, 1'b0);
      wait_done();
      chk(got_pass && !got_fail, "R8 result", 32'({got_pass, got_fail}), 32'h2);
      chk(pulse_arr[2] == 2, "R8 pulses", 32'(pulse_arr[2]), 2);

      // R9 exhausted retries
      send(17'h1FFF3, 16'h0000, 1'b0);
      wait_done();
      chk(!got_pass && got_fail, "R9 result", 32'({got_pass, got_fail}), 32'h1);
      chk(pulse_arr[3] == MR + 1, "R9 pulses", 32'(pulse_arr[3]), 32'(MR + 1));

      // R10 inhibited slot leaves cell untouched
      send(17'h00004, 16'h0F0F, 1'b1);
      wait_done();
      chk(!got_pass && !got_fail, "R10 result", 32'({got_pass, got_fail}), 0);
      chk(mem_arr[4] == 16'hFFFF && pulse_arr[4] == 0, "R10 cell", 32'(mem_arr[4]), 32'hFFFF);

      // R9 cannot raise programmed bits
      send(17'h10001, 16'h4321, 1'b0);
      wait_done();
      chk(!got_pass && got_fail, "R9 overwrite", 32'({got_pass, got_fail}), 32'h1);

      // R7 rewriting identical word, back to back with another
      send(17'h00004, 16'h0F0F, 1'b0);
      wait_done();
      chk(got_pass, "R7 after inhibit", 32'(got_pass), 1);
      send(17'h00005, 16'h8001, 1'b0);
      wait_done();
      chk(got_pass && mem_arr[5] == 16'h8001, "R7 second", 32'(mem_arr[5]), 32'h8001);

      repeat (3) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule